// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address. It fetches two dependent entries from a translation structure in memory. A requester hands in the virtual address together with the physical base of the top-level directory. The walker then reads the directory entry and, from it, the base of the second-level table. Next it reads the table entry and, from that, the physical page frame. It joins that frame with the untouched page offset of the virtual address. Each entry carries a presence flag, and a clear flag at either level ends the walk with a fault.

Memory traffic uses a single-beat word read port. A read request is held, with a valid/ready handshake, until the memory takes it. The read data comes back later, at any latency, on a separate response handshake. The walker serves one request at a time. The finished result is held on the output until the requester takes it. The result is either a translated address or a fault report that names the failing level and carries the virtual address that faulted.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `mem_rd_valid`, `mem_rsp_ready` and `res_valid` are 0.
- R2: The first read of a walk goes to address `{req_root[31:12], vaddr[31:22], 2'b00}`. Bits 11:0 of `req_root` have no effect on it.
- R3: The second read is issued only after a directory entry arrives with bit 0 set. It goes to `{dir_entry[31:12], vaddr[21:12], 2'b00}`, and bits 11:1 of the directory entry have no effect.
- R4: When the table entry has bit 0 set, the result has `res_fault` = 0 and `res_paddr` = `{tbl_entry[31:12], vaddr[11:0]}`.
- R5: A directory entry with bit 0 clear ends the walk without a second read. The result has `res_fault` = 1, `res_fault_lvl` = 0 (directory) and `res_vaddr` equal to the request's virtual address.
- R6: A table entry with bit 0 clear ends the walk with `res_fault` = 1, `res_fault_lvl` = 1 (table), `res_paddr` = 0 and `res_vaddr` equal to the request's virtual address.
- R7: `req_ready` stays 0 from the cycle after a request is accepted until the cycle after the result is taken. It then returns to 1.
- R8: While `res_valid` is 1 and `res_ready` is 0, `res_valid` and every result field hold their values.
- R9: `mem_rd_valid` and `mem_rd_addr` hold until `mem_rd_ready` is seen. Read data is taken only while `mem_rsp_ready` is 1, and that flag never coincides with `mem_rd_valid`. Any response delay is tolerated.
- R10: A successful walk makes exactly two reads and a directory fault exactly one. No read is issued while a result waits to be taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_root | input | 32 | Physical base of the directory (low 12 bits ignored) |
| mem_rd_valid | output | 1 | Read request present |
| mem_rd_ready | input | 1 | Memory takes the read request |
| mem_rd_addr | output | 32 | Word-aligned read address |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_ready | output | 1 | Walker takes read data |
| mem_rsp_data | input | 32 | Entry read from memory |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Requester takes the result |
| res_fault | output | 1 | 1 = walk faulted |
| res_fault_lvl | output | 1 | Faulting level: 0 directory, 1 table |
| res_paddr | output | 32 | Physical address (0 on fault) |
| res_vaddr | output | 32 | Virtual address of the walk |

## Verification
Walks are run with the three entry outcomes: both entries present, directory entry absent, and table entry absent. Comparing them separates the fault level from the data path and shows whether a second read is wrongly issued. Root values and directory entries with their ignored low bits set, as well as virtual addresses of all zeros and all ones, show whether the index fields are taken from the right bit positions. Random addresses, entries, stalls on the read port, response latencies and result back-pressure then test the handshakes. They show whether addresses and results stay put while a transfer is held.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int ADDR_W  = 32;
  localparam int OFF_W   = 12;
  localparam int IDX_W   = 10;
  localparam int ENT_W   = 32;
  localparam int WORD_LG = 2;
  localparam int PFN_W   = ADDR_W - OFF_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [ENT_W-1:0]  entry_t;
  typedef logic [PFN_W-1:0]  pfn_t;
  typedef logic [IDX_W-1:0]  idx_t;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD_DIR = 3'd1,
    ST_WT_DIR = 3'd2,
    ST_RD_TBL = 3'd3,
    ST_WT_TBL = 3'd4,
    ST_DONE   = 3'd5,
    ST_FAULT  = 3'd6
  } walk_state_e;

  // Top index field of the virtual address (directory slot).
  function automatic idx_t upper_index(input addr_t va);
    return va[ADDR_W-1 -: IDX_W];
  endfunction

  // Middle index field of the virtual address (table slot).
  function automatic idx_t lower_index(input addr_t va);
    return va[OFF_W +: IDX_W];
  endfunction

  // Page frame carried in an entry or base register.
  function automatic pfn_t frame_of(input entry_t e);
    return e[ENT_W-1 -: PFN_W];
  endfunction

  // Presence flag of an entry.
  function automatic logic is_present(input entry_t e);
    return e[0];
  endfunction

  // Word address of slot idx inside the page with frame pfn.
  function automatic addr_t slot_addr(input pfn_t pfn, input idx_t idx);
    addr_t a;
    a = '0;
    a[ADDR_W-1 -: PFN_W] = pfn;
    a[WORD_LG +: IDX_W]  = idx;
    return a;
  endfunction

  // Physical address from frame and the untouched page offset.
  function automatic addr_t join_phys(input pfn_t pfn, input addr_t va);
    return {pfn, va[OFF_W-1:0]};
  endfunction

endpackage

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic mem_rd_ready,
  input  logic mem_rsp_valid,
  input  logic rsp_present,
  input  logic res_ready,
  output logic req_ready,
  output logic mem_rd_valid,
  output logic mem_rsp_ready,
  output logic res_valid,
  output logic sel_tbl,
  output logic evt_accept,
  output logic evt_dir_hit,
  output logic evt_dir_miss,
  output logic evt_tbl_hit,
  output logic evt_tbl_miss,
  output logic evt_res_take
);

  walk_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (req_valid)     st_d = ST_RD_DIR;
      ST_RD_DIR: if (mem_rd_ready)  st_d = ST_WT_DIR;
      ST_WT_DIR: if (mem_rsp_valid) st_d = rsp_present ? ST_RD_TBL : ST_FAULT;
      ST_RD_TBL: if (mem_rd_ready)  st_d = ST_WT_TBL;
      ST_WT_TBL: if (mem_rsp_valid) st_d = rsp_present ? ST_DONE : ST_FAULT;
      ST_DONE,
      ST_FAULT:  if (res_ready)     st_d = ST_IDLE;
      default:                      st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign mem_rd_valid  = (st_q == ST_RD_DIR) || (st_q == ST_RD_TBL);
  assign mem_rsp_ready = (st_q == ST_WT_DIR) || (st_q == ST_WT_TBL);
  assign res_valid     = (st_q == ST_DONE) || (st_q == ST_FAULT);
  assign sel_tbl       = (st_q == ST_RD_TBL);

  assign evt_accept   = req_ready && req_valid;
  assign evt_dir_hit  = (st_q == ST_WT_DIR) && mem_rsp_valid && rsp_present;
  assign evt_dir_miss = (st_q == ST_WT_DIR) && mem_rsp_valid && !rsp_present;
  assign evt_tbl_hit  = (st_q == ST_WT_TBL) && mem_rsp_valid && rsp_present;
  assign evt_tbl_miss = (st_q == ST_WT_TBL) && mem_rsp_valid && !rsp_present;
  assign evt_res_take = res_valid && res_ready;

endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  addr_t  req_vaddr,
  input  addr_t  req_root,
  input  entry_t mem_rsp_data,
  input  logic   sel_tbl,
  input  logic   evt_accept,
  input  logic   evt_dir_hit,
  input  logic   evt_dir_miss,
  input  logic   evt_tbl_hit,
  input  logic   evt_tbl_miss,
  output logic   rsp_present,
  output addr_t  mem_rd_addr,
  output logic   res_fault,
  output logic   res_fault_lvl,
  output addr_t  res_paddr,
  output addr_t  res_vaddr
);

  addr_t va_q;
  pfn_t  dir_pfn_q;
  pfn_t  tbl_pfn_q;
  pfn_t  page_pfn_q;
  logic  fault_q;
  logic  lvl_q;

  addr_t dir_slot;
  addr_t tbl_slot;

  assign rsp_present = is_present(mem_rsp_data);
  assign dir_slot    = slot_addr(dir_pfn_q, upper_index(va_q));
  assign tbl_slot    = slot_addr(tbl_pfn_q, lower_index(va_q));
  assign mem_rd_addr = sel_tbl ? tbl_slot : dir_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_q       <= '0;
      dir_pfn_q  <= '0;
      tbl_pfn_q  <= '0;
      page_pfn_q <= '0;
      fault_q    <= 1'b0;
      lvl_q      <= 1'b0;
    end else begin
      if (evt_accept) begin
        va_q      <= req_vaddr;
        dir_pfn_q <= frame_of(req_root);
        fault_q   <= 1'b0;
        lvl_q     <= 1'b0;
      end
      if (evt_dir_hit) tbl_pfn_q <= frame_of(mem_rsp_data);
      if (evt_dir_miss) begin
        fault_q <= 1'b1;
        lvl_q   <= 1'b0;
      end
      if (evt_tbl_hit) page_pfn_q <= frame_of(mem_rsp_data);
      if (evt_tbl_miss) begin
        fault_q <= 1'b1;
        lvl_q   <= 1'b1;
      end
    end
  end

  assign res_fault     = fault_q;
  assign res_fault_lvl = lvl_q;
  assign res_vaddr     = va_q;
  assign res_paddr     = fault_q ? '0 : join_phys(page_pfn_q, va_q);

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic [31:0] req_root,
  output logic        mem_rd_valid,
  input  logic        mem_rd_ready,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rsp_valid,
  output logic        mem_rsp_ready,
  input  logic [31:0] mem_rsp_data,
  output logic        res_valid,
  input  logic        res_ready,
  output logic        res_fault,
  output logic        res_fault_lvl,
  output logic [31:0] res_paddr,
  output logic [31:0] res_vaddr
);

  logic rsp_present;
  logic sel_tbl;
  logic evt_accept;
  logic evt_dir_hit;
  logic evt_dir_miss;
  logic evt_tbl_hit;
  logic evt_tbl_miss;
  logic evt_res_take;

  ptw_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_present   (rsp_present),
    .res_ready     (res_ready),
    .req_ready     (req_ready),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .res_valid     (res_valid),
    .sel_tbl       (sel_tbl),
    .evt_accept    (evt_accept),
    .evt_dir_hit   (evt_dir_hit),
    .evt_dir_miss  (evt_dir_miss),
    .evt_tbl_hit   (evt_tbl_hit),
    .evt_tbl_miss  (evt_tbl_miss),
    .evt_res_take  (evt_res_take)
  );

  ptw_datapath u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_vaddr     (req_vaddr),
    .req_root      (req_root),
    .mem_rsp_data  (mem_rsp_data),
    .sel_tbl       (sel_tbl),
    .evt_accept    (evt_accept),
    .evt_dir_hit   (evt_dir_hit),
    .evt_dir_miss  (evt_dir_miss),
    .evt_tbl_hit   (evt_tbl_hit),
    .evt_tbl_miss  (evt_tbl_miss),
    .rsp_present   (rsp_present),
    .mem_rd_addr   (mem_rd_addr),
    .res_fault     (res_fault),
    .res_fault_lvl (res_fault_lvl),
    .res_paddr     (res_paddr),
    .res_vaddr     (res_vaddr)
  );

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_rd_valid,
  input logic        mem_rd_ready,
  input logic [31:0] mem_rd_addr,
  input logic        mem_rsp_ready,
  input logic        res_valid,
  input logic        res_ready,
  input logic        res_fault,
  input logic        res_fault_lvl,
  input logic [31:0] res_paddr,
  input logic [31:0] res_vaddr,
  input logic        evt_dir_hit,
  input logic        evt_dir_miss,
  input logic        evt_tbl_hit,
  input logic        evt_tbl_miss,
  input logic        evt_res_take
);

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  p_rsp_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_valid && mem_rsp_ready));

  p_rd_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> mem_rd_addr[1:0] == 2'b00);

  p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid || mem_rsp_ready || res_valid) |-> !req_ready);

  p_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_res_take |=> req_ready && !res_valid);

  p_res_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid &&
      $stable({res_fault, res_fault_lvl, res_paddr, res_vaddr}));

  p_no_rd_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !mem_rd_valid);

  p_tbl_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_dir_hit |=> mem_rd_valid && mem_rd_addr[11:2] == res_vaddr[21:12]);

  p_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_tbl_hit |=> res_valid && !res_fault && res_paddr[11:0] == res_vaddr[11:0]);

  p_dir_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_dir_miss |=> res_valid && res_fault && !res_fault_lvl && !mem_rd_valid);

  p_tbl_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_tbl_miss |=> res_valid && res_fault && res_fault_lvl && res_paddr == 32'd0);

endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .mem_rd_valid  (mem_rd_valid),
  .mem_rd_ready  (mem_rd_ready),
  .mem_rd_addr   (mem_rd_addr),
  .mem_rsp_ready (mem_rsp_ready),
  .res_valid     (res_valid),
  .res_ready     (res_ready),
  .res_fault     (res_fault),
  .res_fault_lvl (res_fault_lvl),
  .res_paddr     (res_paddr),
  .res_vaddr     (res_vaddr),
  .evt_dir_hit   (evt_dir_hit),
  .evt_dir_miss  (evt_dir_miss),
  .evt_tbl_hit   (evt_tbl_hit),
  .evt_tbl_miss  (evt_tbl_miss),
  .evt_res_take  (evt_res_take)
);

// File: tb/test_ptw_walker.sv
`timescale 1ns/1ps
module test_ptw_walker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [31:0] req_root = '0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic        res_fault;
  logic        res_fault_lvl;
  logic [31:0] res_paddr;
  logic [31:0] res_vaddr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  ptw_walker i_ptw_walker (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready),
    .req_vaddr (req_vaddr), .req_root (req_root),
    .mem_rd_valid (mem_rd_valid), .mem_rd_ready (mem_rd_ready),
    .mem_rd_addr (mem_rd_addr),
    .mem_rsp_valid (mem_rsp_valid), .mem_rsp_ready (mem_rsp_ready),
    .mem_rsp_data (mem_rsp_data),
    .res_valid (res_valid), .res_ready (res_ready),
    .res_fault (res_fault), .res_fault_lvl (res_fault_lvl),
    .res_paddr (res_paddr), .res_vaddr (res_vaddr)
  );

  // Expected values, written arithmetically.
  function automatic logic [31:0] want_dir(input logic [31:0] root, input logic [31:0] va);
    return (root & 32'hFFFF_F000) + ((va >> 22) * 4);
  endfunction
  function automatic logic [31:0] want_tbl(input logic [31:0] pde, input logic [31:0] va);
    return (pde & 32'hFFFF_F000) + (((va >> 12) % 1024) * 4);
  endfunction
  function automatic logic [31:0] want_pa(input logic [31:0] pte, input logic [31:0] va);
    return (pte & 32'hFFFF_F000) | (va % 4096);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // Waits for a read request, stalls, accepts it and returns its address.
  task automatic serve_read(input int stall, output logic [31:0] addr);
    while (!mem_rd_valid) @(negedge clk);
    addr = mem_rd_addr;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      check("R9 read held", {31'd0, mem_rd_valid}, 32'd1);
      check("R9 address held", mem_rd_addr, addr);
    end
    mem_rd_ready = 1'b1;
    @(negedge clk);
    mem_rd_ready = 1'b0;
  endtask

  task automatic send_rsp(input int lat, input logic [31:0] data);
    for (int i = 0; i < lat; i++) @(negedge clk);
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = data;
    while (!mem_rsp_ready) @(negedge clk);
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 32'hDEAD_BEEF;
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] root,
                      input logic [31:0] pde, input logic [31:0] pte,
                      input int stall, input int lat, input int hold);
    logic [31:0] a;
    logic [31:0] snap;
    int reads;
    reads = 0;
    req_valid = 1'b1;
    req_vaddr = va;
    req_root  = root;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_vaddr = ~va;
    req_root  = ~root;
    check("R7 busy after accept", {31'd0, req_ready}, 32'd0);
    serve_read(stall, a);
    reads++;
    check("R2 directory slot", a, want_dir(root, va));
    send_rsp(lat, pde);
    if (pde[0]) begin
      serve_read(stall, a);
      reads++;
      check("R3 table slot", a, want_tbl(pde, va));
      send_rsp(lat, pte);
    end
    while (!res_valid) begin
      if (mem_rd_valid) reads++;
      @(negedge clk);
    end
    check("R10 read count", reads, (pde[0] ? 2 : 1));
    check("R5 R6 fault vaddr", res_vaddr, va);
    if (!pde[0]) begin
      check("R5 dir fault", {30'd0, res_fault, res_fault_lvl}, 32'b10);
    end else if (!pte[0]) begin
      check("R6 tbl fault", {30'd0, res_fault, res_fault_lvl}, 32'b11);
      check("R6 paddr zero", res_paddr, 32'd0);
    end else begin
      check("R4 no fault", {31'd0, res_fault}, 32'd0);
      check("R4 paddr", res_paddr, want_pa(pte, va));
    end
    snap = res_paddr;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R8 result held", {res_valid, mem_rd_valid, req_ready, res_paddr[28:0]},
            {1'b1, 1'b0, 1'b0, snap[28:0]});
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check("R7 ready after take", {30'd0, req_ready, res_valid}, 32'b10);
  endtask

  initial begin
    int unsigned cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", {28'd0, req_ready, mem_rd_valid, mem_rsp_ready, res_valid}, 32'b1000);
    // Directed corner cases.
    walk(32'h3E80_A123, 32'h0001_0000, 32'h0002_0001, 32'h0ABC_D001, 0, 0, 0);
    walk(32'h3E80_A123, 32'h0001_0FFF, 32'h0002_0FFF, 32'h1234_5FFF, 2, 3, 2); // R2 R3 ignored bits
    walk(32'hFFFF_FFFF, 32'hFFFF_F000, 32'hFFFF_E001, 32'hFFFF_D001, 1, 1, 1);
    walk(32'h0000_0000, 32'h0000_0000, 32'h0000_1001, 32'h0000_2001, 0, 2, 0);
    walk(32'h8040_2ABC, 32'h0030_0000, 32'h0040_0FFE, 32'h0, 3, 0, 3);          // R5
    walk(32'h7FC0_1555, 32'h0030_0000, 32'h0050_0001, 32'h0060_0FFE, 0, 4, 1);  // R6
    // Random walks.
    for (int t = 0; t < 60; t++) begin
      logic [31:0] pde;
      logic [31:0] pte;
      pde = $urandom();
      pte = $urandom();
      pde[0] = ($urandom_range(0, 4) != 0);
      pte[0] = ($urandom_range(0, 4) != 0);
      walk($urandom(), $urandom(), pde, pte,
           $urandom_range(0, 3), $urandom_range(0, 5), $urandom_range(0, 3));
    end
    done = 1'b1;
    finish_run();
  end

endmodule